// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This unit gathers seven interrupt request sources for a small 8-bit processor core and decides when the core must leave its instruction stream for the fixed service vector. Three sources belong to the core group: an external input pin, a change on a group of port pins, and a timer-0 overflow. Their flags and enables sit in one control register, together with a global enable and a peripheral-group enable. Four peripheral sources each have a flag in a peripheral flag register and a matching enable in a peripheral enable register. These sources are nonvolatile-memory write done, ADC conversion done, comparator change and timer-1 overflow.

The core reaches the registers through a simple register port. It also reports each instruction-cycle strobe, marks instruction boundaries and presents its current program counter. The controller accepts a request only at a strobed instruction boundary. When it accepts, it saves the program counter on an internal 8-entry return stack, clears the global enable and tells the core to load the vector address 0x0004. A return strobe pops the saved address back to the core and sets the global enable again.

Top module: `mirq_ctrl`

## Requirements
- R1: Synchronous reset clears every register bit (control register, peripheral flags, peripheral enables), the port reference value and both load strobes, and sets `pc_tgt` to zero.
- R2: Register select 0 is the control register: bit 7 global enable, bit 6 peripheral-group enable, bit 5 timer-0 enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer-0 flag, bit 1 pin flag, bit 0 port-change flag. Selects 1 and 2 are the peripheral flags and enables in bits 3..0: timer-1 overflow bit 0, comparator bit 1, ADC bit 2, nonvolatile write done bit 3. Upper bits read 0. Select 3 reads the synchronised port pins.
- R3: A source event sets its flag in the clock edge that follows, whatever the state of its enable, the peripheral-group enable or the global enable.
- R4: A flag is cleared only by a register write. An event in the same cycle as a write to its register wins, and the flag ends set.
- R5: A core-group source requests service when its flag and enable are both set. A peripheral source also needs the peripheral-group enable. No request is taken while the global enable is clear.
- R6: On acceptance, `vec_load` is high for exactly the following cycle with `pc_tgt` = 0x0004, the global enable reads 0, and `pc_cur` of the accepting cycle is pushed on the return stack.
- R7: A `reti_stb` pulse makes `ret_load` high for the following cycle, with `pc_tgt` equal to the most recently pushed address, and sets the global enable.
- R8: A register write that clears the global enable in a strobed boundary cycle suppresses the acceptance due in that cycle. The flag stays set and is taken at the first boundary after the global enable is set again.
- R9: The external pin passes through two synchroniser flops and a rising-edge detector. Its flag reads 1 after the third clock edge following the rise, and not after the second. A steady high level or a falling edge sets nothing.
- R10: The port-change flag is set while the synchronised port pins differ from a reference that a strobed read of select 3 loads. After such a read the flag, once cleared, stays clear.
- R11: The return stack holds 8 entries of 13 bits. A ninth push without a pop overwrites the oldest entry: 9 pushes and then 9 pops return the last 8 addresses newest first, and the ninth pop returns the newest again.
- R12: Acceptance happens only in a cycle where `cyc_stb` and `insn_bnd` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | Instruction-cycle strobe |
| insn_bnd | input | 1 | Current cycle ends an instruction |
| pc_cur | input | 13 | Program counter to save on acceptance |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| reg_we | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read strobe (loads port reference on select 3) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 6 | Asynchronous port pins watched for change |
| tmr0_ovf | input | 1 | Timer-0 overflow pulse |
| per_evt | input | 4 | Peripheral event pulses, bit order as in R2 |
| vec_load | output | 1 | Core loads `pc_tgt` as the interrupt vector |
| ret_load | output | 1 | Core loads `pc_tgt` as the return address |
| pc_tgt | output | 13 | Target address for the core's program counter |

## Verification
The acceptance decision is driven from a table of register settings. Some rows have a flag with its enable, some a flag without its enable, some an enable without its flag. Some match a peripheral flag to the wrong enable, and some leave out the global or the group enable, so each term of the qualifying condition is shown to be necessary on its own. Directed sequences then separate the finer timing. A write clearing the global enable on a boundary is set against a boundary alone. Boundary without strobe and strobe without boundary are each tried. The pin latency is checked after the second and after the third edge. Port change before and after a reference read is checked, and nine nested entries are unwound to show that the oldest return address is lost.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

    localparam int DATA_W  = 8;
    localparam int PER_N   = 4;

    // control register layout (bit 7 down to bit 0)
    typedef struct packed {
        logic gie;
        logic grp_en;
        logic t0_en;
        logic pin_en;
        logic chg_en;
        logic t0_fl;
        logic pin_fl;
        logic chg_fl;
    } core_reg_t;

    typedef logic [PER_N-1:0] per_vec_t;

    typedef enum logic [1:0] {
        SEL_CORE  = 2'd0,
        SEL_PFLAG = 2'd1,
        SEL_PEN   = 2'd2,
        SEL_PORT  = 2'd3
    } reg_sel_e;

    function automatic logic core_pending(core_reg_t c);
        return (c.t0_fl & c.t0_en) | (c.pin_fl & c.pin_en) | (c.chg_fl & c.chg_en);
    endfunction

    function automatic logic per_pending(per_vec_t fl, per_vec_t en);
        return |(fl & en);
    endfunction

endpackage

// File: rtl/mirq_sync.sv
module mirq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/mirq_regs.sv
module mirq_regs
    import mirq_pkg::*;
#(
    parameter int PORT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_t0,
    input  logic              set_pin,
    input  per_vec_t          set_per,
    input  logic [PORT_W-1:0] port_sync,
    input  logic              gie_clr,
    input  logic              gie_set,
    output core_reg_t         core_q,
    output per_vec_t          pflag_q,
    output per_vec_t          pen_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_P = DATA_W - PER_N;
    localparam int PAD_W = DATA_W - PORT_W;

    logic [PORT_W-1:0] port_ref;
    core_reg_t         core_n;
    per_vec_t          pflag_n;
    logic              chg_evt;
    logic              wr_core, wr_pflag, wr_pen, rd_port;

    assign wr_core  = wr_en && (sel == SEL_CORE);
    assign wr_pflag = wr_en && (sel == SEL_PFLAG);
    assign wr_pen   = wr_en && (sel == SEL_PEN);
    assign rd_port  = rd_en && (sel == SEL_PORT);
    assign chg_evt  = (port_sync != port_ref);

    always_comb begin
        core_n = core_q;
        if (wr_core) core_n = core_reg_t'(wdata);
        if (gie_set) core_n.gie = 1'b1;
        if (gie_clr) core_n.gie = 1'b0;
        core_n.t0_fl  = core_n.t0_fl  | set_t0;
        core_n.pin_fl = core_n.pin_fl | set_pin;
        core_n.chg_fl = core_n.chg_fl | chg_evt;

        pflag_n = wr_pflag ? wdata[PER_N-1:0] : pflag_q;
        pflag_n = pflag_n | set_per;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q   <= '0;
            pflag_q  <= '0;
            pen_q    <= '0;
            port_ref <= '0;
        end else begin
            core_q  <= core_n;
            pflag_q <= pflag_n;
            if (wr_pen)  pen_q    <= wdata[PER_N-1:0];
            if (rd_port) port_ref <= port_sync;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CORE:  rdata = core_q;
            SEL_PFLAG: rdata = {{PAD_P{1'b0}}, pflag_q};
            SEL_PEN:   rdata = {{PAD_P{1'b0}}, pen_q};
            default:   rdata = {{PAD_W{1'b0}}, port_sync};
        endcase
    end

    // R3 / R4: flags set by events, held until a write
    a_r3_t0_sets: assert property (@(posedge clk) disable iff (rst)
        set_t0 |=> core_q.t0_fl);
    a_r4_t0_hold: assert property (@(posedge clk) disable iff (rst)
        (core_q.t0_fl && !wr_core) |=> core_q.t0_fl);
    a_r4_pin_hold: assert property (@(posedge clk) disable iff (rst)
        (core_q.pin_fl && !wr_core) |=> core_q.pin_fl);

    generate
        for (genvar i = 0; i < PER_N; i++) begin : g_per_chk
            a_r3_per_sets: assert property (@(posedge clk) disable iff (rst)
                set_per[i] |=> pflag_q[i]);
            a_r4_per_hold: assert property (@(posedge clk) disable iff (rst)
                (pflag_q[i] && !wr_pflag) |=> pflag_q[i]);
        end
    endgenerate
endmodule

// File: rtl/mirq_ret_stack.sv
module mirq_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] top_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    assign ptr_inc  = (ptr == LAST) ? '0 : ptr + 1'b1;
    assign ptr_dec  = (ptr == '0) ? LAST : ptr - 1'b1;
    assign top_data = mem[ptr_dec];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (push) begin
            mem[ptr] <= push_data;
            ptr      <= ptr_inc;
        end else if (pop) begin
            ptr <= ptr_dec;
        end
    end

    // R11: circular pointer, push and pop never coincide
    a_r11_no_clash: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
    a_r11_push_wraps: assert property (@(posedge clk) disable iff (rst)
        (push && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/mirq_ctrl.sv
module mirq_ctrl
    import mirq_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int PORT_W      = 6,
    parameter int STK_DEPTH   = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_stb,
    input  logic              insn_bnd,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic              reti_stb,
    input  logic              reg_we,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              tmr0_ovf,
    input  logic [PER_N-1:0]  per_evt,
    output logic              vec_load,
    output logic              ret_load,
    output logic [PC_W-1:0]   pc_tgt
);
    reg_sel_e          sel;
    core_reg_t         core_q;
    per_vec_t          pflag_q, pen_q;
    logic              pin_s, pin_d, pin_rise;
    logic [PORT_W-1:0] port_s;
    logic              gie_off_wr, pending, accept;
    logic [PC_W-1:0]   stk_top;

    assign sel = reg_sel_e'(reg_addr);

    mirq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst(rst), .d_async(ext_pin), .d_sync(pin_s));

    mirq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk(clk), .rst(rst), .d_async(port_pins), .d_sync(port_s));

    always_ff @(posedge clk) begin
        if (rst) pin_d <= 1'b0;
        else     pin_d <= pin_s;
    end
    assign pin_rise = pin_s & ~pin_d;

    // acceptance: strobed boundary, global enable, not being cleared now
    assign gie_off_wr = reg_we && (sel == SEL_CORE) && !reg_wdata[DATA_W-1];
    assign pending    = core_pending(core_q) |
                        (core_q.grp_en & per_pending(pflag_q, pen_q));
    assign accept     = cyc_stb && insn_bnd && core_q.gie && pending &&
                        !gie_off_wr && !reti_stb;

    mirq_regs #(.PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_we), .rd_en(reg_rd), .sel(sel), .wdata(reg_wdata),
        .set_t0(tmr0_ovf), .set_pin(pin_rise), .set_per(per_evt),
        .port_sync(port_s),
        .gie_clr(accept), .gie_set(reti_stb),
        .core_q(core_q), .pflag_q(pflag_q), .pen_q(pen_q),
        .rdata(reg_rdata));

    mirq_ret_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk(clk), .rst(rst),
        .push(accept), .push_data(pc_cur),
        .pop(reti_stb), .top_data(stk_top));

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_load <= 1'b0;
            ret_load <= 1'b0;
            pc_tgt   <= '0;
        end else begin
            vec_load <= accept;
            ret_load <= reti_stb;
            if (accept)        pc_tgt <= VEC_ADDR;
            else if (reti_stb) pc_tgt <= stk_top;
        end
    end

    // R6: vector load carries the fixed address with global enable off
    a_r6_vec_addr: assert property (@(posedge clk) disable iff (rst)
        vec_load |-> (pc_tgt == VEC_ADDR));
    a_r6_gie_off: assert property (@(posedge clk) disable iff (rst)
        vec_load |-> !core_q.gie);
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        vec_load |=> !vec_load);
    // R7: return sets the global enable
    a_r7_gie_on: assert property (@(posedge clk) disable iff (rst)
        ret_load |-> core_q.gie);
    // R8: a write clearing the global enable blocks acceptance
    a_r8_gie_write_blocks: assert property (@(posedge clk) disable iff (rst)
        gie_off_wr |=> !vec_load);
    // R12: acceptance only at strobed boundaries
    a_r12_boundary: assert property (@(posedge clk) disable iff (rst)
        (!cyc_stb || !insn_bnd) |=> !vec_load);
    // R9: a pin rise sets its flag
    a_r9_pin_flag: assert property (@(posedge clk) disable iff (rst)
        pin_rise |=> core_q.pin_fl);
endmodule

// File: tb/mirq_ctrl_tb.sv
`timescale 1ns/1ps
module mirq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_stb, insn_bnd, reti_stb, reg_we, reg_rd;
    logic [12:0] pc_cur;
    logic [1:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        ext_pin, tmr0_ovf;
    logic [5:0]  port_pins;
    logic [3:0]  per_evt;
    logic        vec_load, ret_load;
    logic [12:0] pc_tgt;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mirq_ctrl u_dut (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .insn_bnd(insn_bnd),
        .pc_cur(pc_cur), .reti_stb(reti_stb), .reg_we(reg_we), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_pin(ext_pin), .port_pins(port_pins), .tmr0_ovf(tmr0_ovf),
        .per_evt(per_evt), .vec_load(vec_load), .ret_load(ret_load),
        .pc_tgt(pc_tgt));

    // {ctrl[7:0], pen[3:0], pflag[3:0], expect_accept}
    localparam logic [16:0] VECS [12] = '{
        {8'hA4, 4'h0, 4'h0, 1'b1},
        {8'h24, 4'h0, 4'h0, 1'b0},
        {8'h84, 4'h0, 4'h0, 1'b0},
        {8'h92, 4'h0, 4'h0, 1'b1},
        {8'h89, 4'h0, 4'h0, 1'b1},
        {8'h88, 4'h0, 4'h0, 1'b0},
        {8'hC0, 4'h1, 4'h1, 1'b1},
        {8'h80, 4'h1, 4'h1, 1'b0},
        {8'hC0, 4'h8, 4'h4, 1'b0},
        {8'hC0, 4'hF, 4'h8, 1'b1},
        {8'h40, 4'hF, 4'hF, 1'b0},
        {8'hBF, 4'h0, 4'h0, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic boundary(input logic [12:0] pc);
        cyc_stb = 1'b1; insn_bnd = 1'b1; pc_cur = pc;
        tick();
        cyc_stb = 1'b0; insn_bnd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        rst = 1'b1; cyc_stb = 0; insn_bnd = 0; reti_stb = 0; reg_we = 0; reg_rd = 0;
        pc_cur = '0; reg_addr = '0; reg_wdata = '0; ext_pin = 0; tmr0_ovf = 0;
        port_pins = '0; per_evt = '0;
        @(negedge clk);
        do_reset();

        // R1: reset state
        rd(0, v); check("R1 ctrl", v, 8'h00);
        rd(1, v); check("R1 pflag", v, 8'h00);
        rd(2, v); check("R1 pen", v, 8'h00);
        check("R1 vec_load", vec_load, 0);
        check("R1 ret_load", ret_load, 0);
        check("R1 pc_tgt", pc_tgt, 0);

        // R5 / R2: table of enable and flag combinations
        for (int i = 0; i < 12; i++) begin
            logic [7:0] c;
            logic [7:0] exp_c;
            c = VECS[i][16:9];
            wr(2, {4'h0, VECS[i][8:5]});
            wr(1, {4'h0, VECS[i][4:1]});
            wr(0, c);
            boundary(13'h0200 + 13'(i));
            check($sformatf("R5 vector %0d accept", i), vec_load, VECS[i][0]);
            exp_c = VECS[i][0] ? (c & 8'h7F) : c;
            rd(0, v); check($sformatf("R2 vector %0d ctrl", i), v, exp_c);
        end
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);

        // R3: events set flags with every enable clear
        tmr0_ovf = 1'b1; per_evt = 4'b1010;
        tick();
        tmr0_ovf = 1'b0; per_evt = 4'b0000;
        rd(0, v); check("R3 t0 flag", v, 8'h04);
        rd(1, v); check("R3 per flags", v, 8'h0A);

        // R4: hold, write-vs-event priority, clear by write
        repeat (4) tick();
        rd(0, v); check("R4 t0 flag holds", v, 8'h04);
        tmr0_ovf = 1'b1;
        wr(0, 8'h00);
        tmr0_ovf = 1'b0;
        rd(0, v); check("R4 event wins over write", v, 8'h04);
        wr(0, 8'h00);
        rd(0, v); check("R4 write clears", v, 8'h00);
        wr(1, 8'h00);
        rd(1, v); check("R4 per write clears", v, 8'h00);

        // R6 / R7: accept then return
        wr(0, 8'hA4);
        boundary(13'h1ABC);
        check("R6 vec_load", vec_load, 1);
        check("R6 pc_tgt vector", pc_tgt, 13'h0004);
        rd(0, v); check("R6 gie cleared", v, 8'h24);
        tick();
        check("R6 vec_load one cycle", vec_load, 0);
        reti_stb = 1'b1; tick(); reti_stb = 1'b0;
        check("R7 ret_load", ret_load, 1);
        check("R7 return addr", pc_tgt, 13'h1ABC);
        rd(0, v); check("R7 gie set", v, 8'hA4);

        // R8: clearing write on boundary suppresses, request stays
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h24;
        cyc_stb = 1'b1; insn_bnd = 1'b1; pc_cur = 13'h0055;
        tick();
        reg_we = 1'b0; cyc_stb = 1'b0; insn_bnd = 1'b0;
        check("R8 suppressed", vec_load, 0);
        rd(0, v); check("R8 flag pending", v, 8'h24);
        wr(0, 8'hA4);
        boundary(13'h0056);
        check("R8 taken after re-enable", vec_load, 1);
        reti_stb = 1'b1; tick(); reti_stb = 1'b0;
        check("R8 return addr", pc_tgt, 13'h0056);

        // R12: strobe or boundary alone does not accept (gie=1, pending)
        cyc_stb = 1'b1; tick(); cyc_stb = 1'b0;
        check("R12 strobe alone", vec_load, 0);
        insn_bnd = 1'b1; tick(); insn_bnd = 1'b0;
        check("R12 boundary alone", vec_load, 0);
        wr(0, 8'h00);

        // R9: pin latency through synchroniser and edge detector
        ext_pin = 1'b1;
        tick(); tick();
        rd(0, v); check("R9 no flag after 2nd edge", v, 8'h00);
        tick();
        rd(0, v); check("R9 flag after 3rd edge", v, 8'h02);
        wr(0, 8'h00);
        repeat (3) tick();
        rd(0, v); check("R9 steady high no flag", v, 8'h00);
        ext_pin = 1'b0;
        repeat (4) tick();
        rd(0, v); check("R9 falling edge no flag", v, 8'h00);

        // R10: port change against latched reference
        port_pins = 6'h05;
        tick(); tick();
        rd(0, v); check("R10 no flag after 2nd edge", v, 8'h00);
        tick();
        rd(0, v); check("R10 change flag", v, 8'h01);
        reg_rd = 1'b1; reg_addr = 2'd3; #1;
        check("R10 port read value", reg_rdata, 8'h05);
        tick(); reg_rd = 1'b0;
        wr(0, 8'h00);
        repeat (3) tick();
        rd(0, v); check("R10 clear after read", v, 8'h00);
        port_pins = 6'h04;
        repeat (3) tick();
        rd(0, v); check("R10 new change", v, 8'h01);
        reg_rd = 1'b1; reg_addr = 2'd3; tick(); reg_rd = 1'b0;
        wr(0, 8'h00);

        // R11: nine pushes, nine pops
        for (int k = 0; k < 9; k++) begin
            wr(0, 8'hA4);
            boundary(13'h0100 + 13'(k));
            check($sformatf("R11 push %0d accepted", k), vec_load, 1);
        end
        for (int k = 0; k < 9; k++) begin
            reti_stb = 1'b1; tick(); reti_stb = 1'b0;
            check($sformatf("R11 pop %0d", k), pc_tgt,
                  (k < 8) ? (13'h0108 - 13'(k)) : 13'h0108);
        end
        wr(0, 8'h00);

        // R1: reset in mid-run clears state
        wr(0, 8'hFF); wr(1, 8'h0F); wr(2, 8'h0F);
        do_reset();
        rd(0, v); check("R1 mid-run ctrl", v, 8'h00);
        rd(1, v); check("R1 mid-run pflag", v, 8'h00);
        rd(2, v); check("R1 mid-run pen", v, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule